// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and presents them to a processor through a small 32-bit register bus. Each line has an enable bit and a routing bit. The routing bit sends the line either to a normal interrupt output or to a separate fast interrupt output. Lines routed to the normal path carry a 4-bit priority. The controller picks the strongest pending normal line and returns its number as a vector in the upper half of a status word. When nothing is pending, that field holds an all-ones sentinel. A global level register gates the normal output: it is raised only when the winning priority is strictly above the level.

Software reads the normal vector, services the line it names, and repeats until the sentinel comes back. The sources are level-sensitive, so a line remains pending for as long as it is both active and enabled. Clearing its enable bit is therefore the acknowledge. A force register lets software raise any line without its input being driven. All pending, vector and output values are registered views of the state and lag a bus write or an input change by exactly one clock.

Top module: `irq_vector_ctrl`

## Requirements
- R1: Sources 0 to 31 occupy bits 0 to 31 of the low register of every per-source pair, and sources 32 to 63 occupy bit (source minus 32) of the high register. Low/high byte offsets are: enable 0x14/0x10, type 0x1C/0x18, raw source 0x4C/0x48, force 0x54/0x50, normal pending 0x5C/0x58 and fast pending 0x64/0x60.
- R2: Reset puts the registers in this state:
  - control (0x00) reads 0.
  - Level (0x04) reads 0x1F.
  - All enable, type, force and priority bits read 0.
  - Both vector words read 0xFFFF0000.
  - Both interrupt outputs are low.
- R3: A write of value v to the enable-by-number address (0x08) sets enable bit v, and a write of v to the disable-by-number address (0x0C) clears enable bit v, both only when v < 64. A value of 64 or more changes no enable bit.
- R4: Let active = raw source OR force. Normal pending = active AND enable AND NOT type. Fast pending = active AND enable AND type, so a type bit of 1 selects the fast path. A source is never pending on both paths.
- R5: The normal vector word (0x40) holds the number of the pending normal source with the greatest priority in bits [31:16]. A tie goes to the higher source number. Bits [15:0] read 0. The word reads 0xFFFF0000 when no normal source is pending. The level register does not affect this word.
- R6: Priority register x (x = 0 to 7) sits at byte offset 0x20 + 4*(7 - x). The 4-bit priority of source n is bits [4*(n mod 8)+3 : 4*(n mod 8)] of priority register n/8.
- R7: The normal output is high exactly when a normal source is pending whose priority is strictly greater than the 5-bit level (0x04). A level of 0x1F therefore blocks all normal sources.
- R8: The fast vector word (0x44) holds the highest-numbered fast pending source in bits [31:16], or reads 0xFFFF0000 when there is none. The fast output is high exactly when any fast source is pending.
- R9: Pending follows the source level. A source that drops, or whose enable is cleared, leaves the pending and vector views. A forced source stays pending after its input drops.
- R10: Pending, vector and output values reflect a change of state or input one clock edge after the edge that caused it.
- R11: The raw source words show only the input lines and never the force bits. Force bits take part in pending exactly as an active input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 64 | Level-sensitive interrupt lines |
| nirq_out | output | 1 | Normal interrupt request |
| firq_out | output | 1 | Fast interrupt request |

## Verification
The hardest situations to reach are ties and the strict level boundary. A tie needs two sources at equal priority that are pending together on the normal path. The level check needs the winning priority to sit exactly at the level and then one step above it. The stimulus table raises a low and a high source with equal priorities and then splits them. It then moves one of them to the fast path, and finally removes it by disable-by-number. Each step is chosen so that the vector word changes and shows the effect. Directed steps then walk the level register across the winner's priority and catch the one-cycle lag on the output. They also write out-of-range numbers whose low six bits name an existing source, so that a design decoding only those bits would change an enable.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC   = 64;
  localparam int HALF   = NSRC / 2;
  localparam int PRIO_W = 4;
  localparam int LVL_W  = 5;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int FPR    = 32 / PRIO_W;        // priority fields per register
  localparam int NPREG  = NSRC / FPR;         // number of priority registers
  localparam logic [15:0] NO_VEC = 16'hFFFF;

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_LVL   = 8'h04;
  localparam logic [7:0] A_ENNUM = 8'h08;
  localparam logic [7:0] A_DSNUM = 8'h0C;
  localparam logic [7:0] A_ENH   = 8'h10;
  localparam logic [7:0] A_ENL   = 8'h14;
  localparam logic [7:0] A_TYH   = 8'h18;
  localparam logic [7:0] A_TYL   = 8'h1C;
  localparam logic [7:0] A_NVEC  = 8'h40;
  localparam logic [7:0] A_FVEC  = 8'h44;
  localparam logic [7:0] A_SRH   = 8'h48;
  localparam logic [7:0] A_SRL   = 8'h4C;
  localparam logic [7:0] A_FRH   = 8'h50;
  localparam logic [7:0] A_FRL   = 8'h54;
  localparam logic [7:0] A_NPH   = 8'h58;
  localparam logic [7:0] A_NPL   = 8'h5C;
  localparam logic [7:0] A_FPH   = 8'h60;
  localparam logic [7:0] A_FPL   = 8'h64;

  typedef struct packed {
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] pri;
  } win_t;

  // priority register addresses run downward: 0x3C holds sources 0..7
  function automatic logic [2:0] preg_sel(logic [7:0] addr);
    return ~addr[4:2];
  endfunction

  function automatic logic is_preg(logic [7:0] addr);
    return (addr[7:5] == 3'b001) && (addr[1:0] == 2'b00);
  endfunction

  // strongest pending source; >= lets a later (higher) index win a tie
  function automatic win_t pick_normal(logic [NSRC-1:0] pend,
                                       logic [NSRC*PRIO_W-1:0] pri);
    win_t w;
    w = '0;
    for (int n = 0; n < NSRC; n++) begin
      if (pend[n] && (!w.hit || pri[n*PRIO_W +: PRIO_W] >= w.pri)) begin
        w.hit = 1'b1;
        w.idx = IDX_W'(n);
        w.pri = pri[n*PRIO_W +: PRIO_W];
      end
    end
    return w;
  endfunction

  function automatic win_t pick_highest(logic [NSRC-1:0] pend);
    win_t w;
    w = '0;
    for (int n = 0; n < NSRC; n++) begin
      if (pend[n]) begin
        w.hit = 1'b1;
        w.idx = IDX_W'(n);
      end
    end
    return w;
  endfunction

  function automatic logic [31:0] vec_word(win_t w);
    return w.hit ? {{(16-IDX_W){1'b0}}, w.idx, 16'h0000} : {NO_VEC, 16'h0000};
  endfunction
endpackage

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [7:0]                   bus_addr,
  input  logic                         bus_we,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  ctrl_q,
  output logic [LVL_W-1:0]             lvl_q,
  output logic [NSRC-1:0]              en_q,
  output logic [NSRC-1:0]              typ_q,
  output logic [NSRC-1:0]              frc_q,
  output logic [NPREG-1:0][31:0]       prio_q
);
  logic num_ok;
  assign num_ok = (bus_wdata[31:IDX_W] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lvl_q  <= '1;
      en_q   <= '0;
      typ_q  <= '0;
      frc_q  <= '0;
      prio_q <= '0;
    end else if (bus_we) begin
      if (is_preg(bus_addr)) begin
        prio_q[preg_sel(bus_addr)] <= bus_wdata;
      end else begin
        case (bus_addr)
          A_CTRL:  ctrl_q <= bus_wdata;
          A_LVL:   lvl_q  <= bus_wdata[LVL_W-1:0];
          A_ENNUM: if (num_ok) en_q[bus_wdata[IDX_W-1:0]] <= 1'b1;
          A_DSNUM: if (num_ok) en_q[bus_wdata[IDX_W-1:0]] <= 1'b0;
          A_ENH:   en_q[NSRC-1:HALF]  <= bus_wdata;
          A_ENL:   en_q[HALF-1:0]     <= bus_wdata;
          A_TYH:   typ_q[NSRC-1:HALF] <= bus_wdata;
          A_TYL:   typ_q[HALF-1:0]    <= bus_wdata;
          A_FRH:   frc_q[NSRC-1:HALF] <= bus_wdata;
          A_FRL:   frc_q[HALF-1:0]    <= bus_wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vic_resolver.sv
module vic_resolver
  import vic_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src_in,
  input  logic [NSRC-1:0]        en_q,
  input  logic [NSRC-1:0]        typ_q,
  input  logic [NSRC-1:0]        frc_q,
  input  logic [NPREG-1:0][31:0] prio_q,
  input  logic [LVL_W-1:0]       lvl_q,
  output logic [NSRC-1:0]        src_q,
  output logic [NSRC-1:0]        npend_q,
  output logic [NSRC-1:0]        fpend_q,
  output logic [31:0]            nvec_q,
  output logic [31:0]            fvec_q,
  output logic                   nirq_q,
  output logic                   firq_q
);
  logic [NSRC*PRIO_W-1:0] pri_flat;
  logic [NSRC-1:0]        active, npend_c, fpend_c;
  win_t                   nwin, fwin;
  logic                   nirq_c;

  for (genvar x = 0; x < NPREG; x++) begin : g_flat
    assign pri_flat[x*32 +: 32] = prio_q[x];
  end

  always_comb begin
    active  = src_in | frc_q;
    npend_c = active & en_q & ~typ_q;
    fpend_c = active & en_q & typ_q;
    nwin    = pick_normal(npend_c, pri_flat);
    fwin    = pick_highest(fpend_c);
    nirq_c  = nwin.hit && ({1'b0, nwin.pri} > lvl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      npend_q <= '0;
      fpend_q <= '0;
      nvec_q  <= {NO_VEC, 16'h0000};
      fvec_q  <= {NO_VEC, 16'h0000};
      nirq_q  <= 1'b0;
      firq_q  <= 1'b0;
    end else begin
      src_q   <= src_in;
      npend_q <= npend_c;
      fpend_q <= fpend_c;
      nvec_q  <= vec_word(nwin);
      fvec_q  <= vec_word(fwin);
      nirq_q  <= nirq_c;
      firq_q  <= |fpend_c;
    end
  end
endmodule

// File: rtl/vic_readmux.sv
module vic_readmux
  import vic_pkg::*;
(
  input  logic [7:0]             bus_addr,
  input  logic [31:0]            ctrl_q,
  input  logic [LVL_W-1:0]       lvl_q,
  input  logic [NSRC-1:0]        en_q,
  input  logic [NSRC-1:0]        typ_q,
  input  logic [NSRC-1:0]        frc_q,
  input  logic [NSRC-1:0]        src_q,
  input  logic [NSRC-1:0]        npend_q,
  input  logic [NSRC-1:0]        fpend_q,
  input  logic [NPREG-1:0][31:0] prio_q,
  input  logic [31:0]            nvec_q,
  input  logic [31:0]            fvec_q,
  output logic [31:0]            bus_rdata
);
  always_comb begin
    bus_rdata = '0;
    if (is_preg(bus_addr)) begin
      bus_rdata = prio_q[preg_sel(bus_addr)];
    end else begin
      case (bus_addr)
        A_CTRL:  bus_rdata = ctrl_q;
        A_LVL:   bus_rdata = {{(32-LVL_W){1'b0}}, lvl_q};
        A_ENH:   bus_rdata = en_q[NSRC-1:HALF];
        A_ENL:   bus_rdata = en_q[HALF-1:0];
        A_TYH:   bus_rdata = typ_q[NSRC-1:HALF];
        A_TYL:   bus_rdata = typ_q[HALF-1:0];
        A_NVEC:  bus_rdata = nvec_q;
        A_FVEC:  bus_rdata = fvec_q;
        A_SRH:   bus_rdata = src_q[NSRC-1:HALF];
        A_SRL:   bus_rdata = src_q[HALF-1:0];
        A_FRH:   bus_rdata = frc_q[NSRC-1:HALF];
        A_FRL:   bus_rdata = frc_q[HALF-1:0];
        A_NPH:   bus_rdata = npend_q[NSRC-1:HALF];
        A_NPL:   bus_rdata = npend_q[HALF-1:0];
        A_FPH:   bus_rdata = fpend_q[NSRC-1:HALF];
        A_FPL:   bus_rdata = fpend_q[HALF-1:0];
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              nirq_out,
  output logic              firq_out
);
  logic [31:0]            ctrl_q;
  logic [LVL_W-1:0]       lvl_q;
  logic [NSRC-1:0]        en_q, typ_q, frc_q;
  logic [NPREG-1:0][31:0] prio_q;
  logic [NSRC-1:0]        src_q, npend_q, fpend_q;
  logic [31:0]            nvec_q, fvec_q;

  vic_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .lvl_q(lvl_q), .en_q(en_q),
    .typ_q(typ_q), .frc_q(frc_q), .prio_q(prio_q)
  );

  vic_resolver u_res (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .en_q(en_q), .typ_q(typ_q),
    .frc_q(frc_q), .prio_q(prio_q), .lvl_q(lvl_q), .src_q(src_q),
    .npend_q(npend_q), .fpend_q(fpend_q), .nvec_q(nvec_q), .fvec_q(fvec_q),
    .nirq_q(nirq_out), .firq_q(firq_out)
  );

  vic_readmux u_rd (
    .bus_addr(bus_addr), .ctrl_q(ctrl_q), .lvl_q(lvl_q), .en_q(en_q),
    .typ_q(typ_q), .frc_q(frc_q), .src_q(src_q), .npend_q(npend_q),
    .fpend_q(fpend_q), .prio_q(prio_q), .nvec_q(nvec_q), .fvec_q(fvec_q),
    .bus_rdata(bus_rdata)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      bus_addr,
  input logic            bus_we,
  input logic [31:0]     bus_wdata,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] npend_q,
  input logic [NSRC-1:0] fpend_q,
  input logic [31:0]     nvec_q,
  input logic [31:0]     fvec_q,
  input logic            nirq_out,
  input logic            firq_out
);
  logic en_wr, ds_wr;
  assign en_wr = bus_we && bus_addr == A_ENNUM && bus_wdata < 32'(NSRC);
  assign ds_wr = bus_we && bus_addr == A_DSNUM && bus_wdata < 32'(NSRC);

  // R3
  en_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> en_q[$past(bus_wdata[IDX_W-1:0])]);
  // R3
  ds_num_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_wr |=> !en_q[$past(bus_wdata[IDX_W-1:0])]);
  // R4
  path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (npend_q & fpend_q) == '0);
  // R5
  nvec_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nvec_q[31:16] == NO_VEC) == (npend_q == '0));
  // R7
  nirq_has_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nirq_out |-> (nvec_q[31:16] != NO_VEC));
  // R8
  firq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    firq_out == (fpend_q != '0) && firq_out == (fvec_q[31:16] != NO_VEC));
endmodule

bind irq_vector_ctrl vic_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .en_q(en_q), .npend_q(npend_q), .fpend_q(fpend_q),
  .nvec_q(nvec_q), .fvec_q(fvec_q), .nirq_out(nirq_out), .firq_out(firq_out)
);

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        nirq_out, firq_out;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .nirq_out(nirq_out), .firq_out(firq_out)
  );

  always #4 clk = ~clk;

  // entry: [85:82] req, [81:80] kind (0 write, 1 src low, 2 src high, 3 none),
  //        [79:72] write addr, [71:40] data, [39:32] check addr, [31:0] expected
  function automatic logic [85:0] ent(int req, int kind, logic [7:0] wa,
                                      logic [31:0] wd, logic [7:0] ca,
                                      logic [31:0] ce);
    return {4'(req), 2'(kind), wa, wd, ca, ce};
  endfunction

  localparam int NT = 20;
  localparam logic [85:0] TBL [NT] = '{
    ent(7,  0, 8'h04, 32'd0,        8'h04, 32'h0),          // R7 level to 0
    ent(3,  0, 8'h08, 32'd5,        8'h14, 32'h20),         // R3 enable 5
    ent(5,  1, 8'h00, 32'h20,       8'h40, 32'h0005_0000),  // R5 src 5 alone
    ent(1,  0, 8'h08, 32'd40,       8'h10, 32'h100),        // R1 enable 40 in high half
    ent(5,  2, 8'h00, 32'h100,      8'h40, 32'h0028_0000),  // R5 tie -> 40
    ent(6,  0, 8'h3C, 32'h0030_0000,8'h40, 32'h0005_0000),  // R6 src 5 prio 3
    ent(6,  0, 8'h28, 32'h3,        8'h40, 32'h0028_0000),  // R6 src 40 prio 3, tie
    ent(4,  0, 8'h18, 32'h100,      8'h40, 32'h0005_0000),  // R4 40 to fast
    ent(8,  3, 8'h00, 32'h0,        8'h44, 32'h0028_0000),  // R8 fast vector
    ent(4,  3, 8'h00, 32'h0,        8'h60, 32'h100),        // R4 fast pend high
    ent(4,  3, 8'h00, 32'h0,        8'h5C, 32'h20),         // R4 normal pend low
    ent(4,  3, 8'h00, 32'h0,        8'h58, 32'h0),          // R4 normal pend high
    ent(9,  0, 8'h0C, 32'd5,        8'h40, 32'hFFFF_0000),  // R9 disable acks
    ent(3,  0, 8'h0C, 32'd104,      8'h10, 32'h100),        // R3 104 ignored
    ent(3,  0, 8'h08, 32'd69,       8'h14, 32'h0),          // R3 69 ignored
    ent(9,  0, 8'h08, 32'd0,        8'h40, 32'hFFFF_0000),  // R9 src 0 idle
    ent(11, 0, 8'h54, 32'h1,        8'h40, 32'h0000_0000),  // R11 force src 0
    ent(11, 3, 8'h00, 32'h0,        8'h4C, 32'h20),         // R11 raw excludes force
    ent(6,  0, 8'h3C, 32'h0030_0007,8'h5C, 32'h1),          // R6 prio src 0 = 7
    ent(9,  1, 8'h00, 32'h0,        8'h5C, 32'h1)           // R9 forced stays
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R2 reset state
    bus_read(8'h00, rd); check("R2 ctrl", rd, 32'h0);
    bus_read(8'h04, rd); check("R2 level", rd, 32'h1F);
    bus_read(8'h10, rd); check("R2 enable high", rd, 32'h0);
    bus_read(8'h1C, rd); check("R2 type low", rd, 32'h0);
    bus_read(8'h3C, rd); check("R2 priority", rd, 32'h0);
    bus_read(8'h40, rd); check("R2 normal vector", rd, 32'hFFFF_0000);
    bus_read(8'h44, rd); check("R2 fast vector", rd, 32'hFFFF_0000);
    check("R2 nirq", {31'b0, nirq_out}, 32'h0);
    check("R2 firq", {31'b0, firq_out}, 32'h0);

    for (int i = 0; i < NT; i++) begin
      logic [85:0] e;
      e = TBL[i];
      case (e[81:80])
        2'd0: bus_write(e[79:72], e[71:40]);
        2'd1: begin @(negedge clk); src_in[31:0]  = e[71:40]; @(negedge clk); end
        2'd2: begin @(negedge clk); src_in[63:32] = e[71:40]; @(negedge clk); end
        default: settle();
      endcase
      settle();
      bus_read(e[39:32], rd);
      checks++;
      if (rd !== e[31:0]) begin
        errors++;
        $display("FAIL R%0d row %0d actual=%h expected=%h", e[85:82], i, rd, e[31:0]);
      end
    end

    // state: src0 forced prio 7 normal, src40 active fast, level 0
    check("R7 above level", {31'b0, nirq_out}, 32'h1);
    bus_write(8'h04, 32'd7);
    settle();
    check("R7 equal level blocks", {31'b0, nirq_out}, 32'h0);
    bus_read(8'h40, rd); check("R5 vector ignores level", rd, 32'h0000_0000);
    bus_write(8'h04, 32'd6);
    check("R10 one-edge lag", {31'b0, nirq_out}, 32'h0);
    settle();
    check("R7 level 6 passes", {31'b0, nirq_out}, 32'h1);
    check("R8 fast out", {31'b0, firq_out}, 32'h1);
    @(negedge clk); src_in[63:32] = '0;
    settle(); settle();
    check("R9 fast out drops", {31'b0, firq_out}, 32'h0);
    bus_read(8'h44, rd); check("R8 fast sentinel", rd, 32'hFFFF_0000);

    // R2 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    settle();
    bus_read(8'h04, rd); check("R2 level after reset", rd, 32'h1F);
    bus_read(8'h14, rd); check("R2 enable low after reset", rd, 32'h0);
    bus_read(8'h54, rd); check("R2 force low after reset", rd, 32'h0);
    bus_read(8'h40, rd); check("R2 vector after reset", rd, 32'hFFFF_0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule